// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the register interface that sits between a byte-wide peripheral bus and the counting engines of a three-channel interval timer. It has four byte ports. Three are channel data ports. The fourth is a write-only command port that programs one channel at a time. A command selects the channel's operating mode and counting format. It also selects the order in which reload bytes are accepted: low byte only, high byte only, or low then high. Alternatively, a command can freeze the channel's current count for a consistent two-byte read.

Each channel accepts its reload value one byte at a time. When the last byte of a programming sequence lands, the block presents the assembled 16-bit reload value and a one-cycle strobe to that channel's counting engine. Reads of a data port return the live count, or the frozen count while a latch is pending. The low byte is returned first, then the high byte. A command that selects the fourth channel code requests status readback. It is not executed and raises a one-cycle error pulse. A data byte sent to a channel that has never been given a command also raises the error pulse.

Top module: `tmr_regfront`

## Requirements
- R1: Address 0, 1 and 2 select the data ports of channels 0, 1 and 2, and address 3 selects the command port. A read of address 3 returns 0x00 in the cycle after the read strobe and changes no channel's read order or latch state.
- R2: A command write applies to the channel in bits 7:6. Unless the command is a latch command, the channel's mode output takes bits 3:1 and its format output takes bit 0. A latch command leaves the mode and format outputs unchanged.
- R3: A command write with bits 7:6 equal to 3 changes no channel state and drives `err_pulse` high for one cycle.
- R4: Bits 5:4 give the access order. A value of 1 means low byte only. In this order every data write replaces bits 7:0 of the reload value and completes the count.
- R5: An access order of 2 means high byte only. In this order every data write replaces bits 15:8 of the reload value and completes the count.
- R6: An access order of 3 means low byte then high byte. The first write after the command replaces bits 7:0 and the next write replaces bits 15:8, and the pair repeats. Only the high-byte write completes the count.
- R7: Data-port reads of a channel alternate between the low byte and the high byte, starting with the low byte after reset. Without a pending latch they return the live counter input.
- R8: An access order of 0 marks a latch command. It copies the channel's live counter into a holding register, and reads return that held value until its high byte has been read. The latch is then released.
- R9: A latch command issued while that channel's latch is still pending has no effect.
- R10: A data write to a channel that has received no programming command since reset leaves the reload value unchanged, produces no completion strobe and drives `err_pulse` high for one cycle.
- R11: After reset, reload values, mode and format outputs, strobes, `err_pulse` and `bus_rdata` are all zero.
- R12: Completing a count drives that channel's `ch_load_stb` bit high for exactly the cycle after the write, together with the updated reload value. At most one strobe bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Port select |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| cnt_live | input | NUM_CH*16 | Live counter of each channel, channel 0 in the low bits |
| ch_mode | output | NUM_CH*3 | Operating mode of each channel |
| ch_bcd | output | NUM_CH | Counting-format select of each channel |
| ch_reload | output | NUM_CH*16 | Assembled reload value of each channel |
| ch_load_stb | output | NUM_CH | One-cycle count-complete strobe per channel |
| err_pulse | output | 1 | One-cycle error: readback command or write to an unprogrammed channel |

## Verification
The bound checker watches four properties on every cycle. Reload values and modes hold still unless a write to the matching port occurs. A strobe bit follows only a write to its own data port, and at most one strobe bit is high at a time. Readback commands always raise the error pulse, and command-port reads return zero. The byte sequencing depends on hidden per-channel state, so only the bench scenarios can show it. These cover the low/high alternation, the frozen value across changing live counts, the ignored second latch, and the release after the high byte.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Access order field of a command word (bits 5:4)
  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_e;

  // Which data byte a channel is waiting for
  typedef enum logic [1:0] {
    EXP_NONE = 2'd0,
    EXP_LO   = 2'd1,
    EXP_HI   = 2'd2
  } expect_e;

  // Command word, most significant field first
  typedef struct packed {
    logic [1:0] sel;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } cmd_t;

  localparam logic [1:0] SEL_READBACK = 2'd3;
  localparam logic [1:0] ADDR_CMD     = 2'd3;

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output cmd_t              cmd,
  output logic [NUM_CH-1:0] cmd_hit,
  output logic [NUM_CH-1:0] data_hit,
  output logic [NUM_CH-1:0] rd_hit,
  output logic              rb_err,
  output logic              bad_addr_wr
);

  logic cmd_wr;
  logic in_range;

  assign cmd          = cmd_t'(bus_wdata[7:0]);
  assign cmd_wr       = bus_wr && (bus_addr == ADDR_CMD);
  assign rb_err       = cmd_wr && (cmd.sel == SEL_READBACK);
  assign in_range     = (32'(bus_addr) < NUM_CH);
  assign bad_addr_wr  = bus_wr && (bus_addr != ADDR_CMD) && !in_range;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign cmd_hit[c]  = cmd_wr && (cmd.sel == 2'(c));
    assign data_hit[c] = bus_wr && (bus_addr == 2'(c));
    assign rd_hit[c]   = bus_rd && (bus_addr == 2'(c));
  end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_hit,
  input  cmd_t              cmd,
  input  logic              data_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_hit,
  input  logic [CNT_W-1:0]  live,
  output logic [2:0]        mode,
  output logic              bcd,
  output logic [CNT_W-1:0]  reload,
  output logic              load_stb,
  output logic [DATA_W-1:0] rd_byte,
  output logic              wr_err
);

  expect_e            exp_q,    exp_d;
  acc_e               acc_q,    acc_d;
  logic [2:0]         mode_q,   mode_d;
  logic               bcd_q,    bcd_d;
  logic [CNT_W-1:0]   reload_q, reload_d;
  logic               stb_q,    stb_d;
  logic               lat_q,    lat_d;
  logic [CNT_W-1:0]   hold_q,   hold_d;
  logic               rdhi_q,   rdhi_d;
  logic [CNT_W-1:0]   rd_src;

  // Next-state logic
  always_comb begin
    exp_d    = exp_q;
    acc_d    = acc_q;
    mode_d   = mode_q;
    bcd_d    = bcd_q;
    reload_d = reload_q;
    stb_d    = 1'b0;
    lat_d    = lat_q;
    hold_d   = hold_q;
    rdhi_d   = rdhi_q;

    if (cmd_hit) begin
      if (cmd.acc == ACC_LATCH) begin
        if (!lat_q) begin
          hold_d = live;
          lat_d  = 1'b1;
        end
      end else begin
        acc_d  = cmd.acc;
        mode_d = cmd.mode;
        bcd_d  = cmd.bcd;
        exp_d  = (cmd.acc == ACC_HI) ? EXP_HI : EXP_LO;
      end
    end

    if (data_hit) begin
      unique case (exp_q)
        EXP_LO: begin
          reload_d[DATA_W-1:0] = wdata;
          if (acc_q == ACC_LOHI) exp_d = EXP_HI;
          else                   stb_d = 1'b1;
        end
        EXP_HI: begin
          reload_d[CNT_W-1:DATA_W] = wdata;
          stb_d = 1'b1;
          if (acc_q == ACC_LOHI) exp_d = EXP_LO;
        end
        default: ;
      endcase
    end

    if (rd_hit) begin
      rdhi_d = !rdhi_q;
      if (rdhi_q && lat_q) lat_d = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q    <= EXP_NONE;
      acc_q    <= ACC_LATCH;
      mode_q   <= '0;
      bcd_q    <= 1'b0;
      reload_q <= '0;
      stb_q    <= 1'b0;
      lat_q    <= 1'b0;
      hold_q   <= '0;
      rdhi_q   <= 1'b0;
    end else begin
      exp_q    <= exp_d;
      acc_q    <= acc_d;
      mode_q   <= mode_d;
      bcd_q    <= bcd_d;
      reload_q <= reload_d;
      stb_q    <= stb_d;
      lat_q    <= lat_d;
      hold_q   <= hold_d;
      rdhi_q   <= rdhi_d;
    end
  end

  assign rd_src   = lat_q ? hold_q : live;
  assign rd_byte  = rdhi_q ? rd_src[CNT_W-1:DATA_W] : rd_src[DATA_W-1:0];
  assign wr_err   = data_hit && (exp_q == EXP_NONE);
  assign mode     = mode_q;
  assign bcd      = bcd_q;
  assign reload   = reload_q;
  assign load_stb = stb_q;

endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input  logic [NUM_CH*DATA_W-1:0] ch_bytes,
  input  logic [1:0]               addr,
  output logic [DATA_W-1:0]        rd_byte
);

  always_comb begin
    rd_byte = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == 2'(c)) rd_byte = ch_bytes[c*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/tmr_regfront.sv
module tmr_regfront
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               bus_addr,
  input  logic                     bus_wr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     bus_rd,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NUM_CH*CNT_W-1:0]  cnt_live,
  output logic [NUM_CH*3-1:0]      ch_mode,
  output logic [NUM_CH-1:0]        ch_bcd,
  output logic [NUM_CH*CNT_W-1:0]  ch_reload,
  output logic [NUM_CH-1:0]        ch_load_stb,
  output logic                     err_pulse
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cmd_t                     cmd;
  logic [NUM_CH-1:0]        cmd_hit, data_hit, rd_hit, wr_err;
  logic                     rb_err, bad_addr_wr;
  logic [NUM_CH*DATA_W-1:0] ch_bytes;
  logic [DATA_W-1:0]        mux_byte;

  tmr_cmd_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dec (
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .cmd         (cmd),
    .cmd_hit     (cmd_hit),
    .data_hit    (data_hit),
    .rd_hit      (rd_hit),
    .rb_err      (rb_err),
    .bad_addr_wr (bad_addr_wr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_chan_regs #(.DATA_W(DATA_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .cmd_hit  (cmd_hit[c]),
      .cmd      (cmd),
      .data_hit (data_hit[c]),
      .wdata    (bus_wdata),
      .rd_hit   (rd_hit[c]),
      .live     (cnt_live[c*CNT_W +: CNT_W]),
      .mode     (ch_mode[c*3 +: 3]),
      .bcd      (ch_bcd[c]),
      .reload   (ch_reload[c*CNT_W +: CNT_W]),
      .load_stb (ch_load_stb[c]),
      .rd_byte  (ch_bytes[c*DATA_W +: DATA_W]),
      .wr_err   (wr_err[c])
    );
  end

  tmr_read_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rmux (
    .ch_bytes (ch_bytes),
    .addr     (bus_addr),
    .rd_byte  (mux_byte)
  );

  // Read data and error pulse registers
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              err_d,   err_q;

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) rdata_d = (bus_addr == ADDR_CMD) ? '0 : mux_byte;
    err_d = rb_err || bad_addr_wr || (|wr_err);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign err_pulse = err_q;

endmodule

// File: rtl/tmr_regfront_chk.sv
module tmr_regfront_chk #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              bus_addr,
  input logic                    bus_wr,
  input logic [DATA_W-1:0]       bus_wdata,
  input logic                    bus_rd,
  input logic [DATA_W-1:0]       bus_rdata,
  input logic [NUM_CH*3-1:0]     ch_mode,
  input logic [NUM_CH*CNT_W-1:0] ch_reload,
  input logic [NUM_CH-1:0]       ch_load_stb,
  input logic                    err_pulse
);

  // Readback command always flags an error (R3)
  p_readback_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && bus_wdata[7:6] == 2'b11) |=> err_pulse);

  // Command port reads back as zero (R1)
  p_cmd_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd3) |=> (bus_rdata == '0));

  // Reload values only move after a data-port write (R4)
  p_reload_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr != 2'd3) |=> $stable(ch_reload));

  // Modes only move after a command write (R2)
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd3) |=> $stable(ch_mode));

  // No error without a write (R10)
  p_err_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> !err_pulse);

  // At most one completion strobe per cycle (R12)
  p_stb_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load_stb));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_stb
    // Strobe only follows a write to the same channel's data port (R12)
    p_stb_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load_stb[c] |-> $past(bus_wr && bus_addr == 2'(c)));
  end

endmodule

bind tmr_regfront tmr_regfront_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .ch_mode     (ch_mode),
  .ch_reload   (ch_reload),
  .ch_load_stb (ch_load_stb),
  .err_pulse   (err_pulse)
);

// File: tb/test_tmr_regfront.sv
`timescale 1ns/1ps
module test_tmr_regfront;

  localparam int NUM_CH = 3;
  localparam int CNT_W  = 16;

  logic                    clk;
  logic                    rst_n;
  logic [1:0]              bus_addr;
  logic                    bus_wr;
  logic [7:0]              bus_wdata;
  logic                    bus_rd;
  logic [7:0]              bus_rdata;
  logic [NUM_CH*CNT_W-1:0] cnt_live;
  logic [NUM_CH*3-1:0]     ch_mode;
  logic [NUM_CH-1:0]       ch_bcd;
  logic [NUM_CH*CNT_W-1:0] ch_reload;
  logic [NUM_CH-1:0]       ch_load_stb;
  logic                    err_pulse;

  int checks = 0;
  int fails  = 0;

  tmr_regfront i_tmr_regfront (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cnt_live(cnt_live), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
    .ch_reload(ch_reload), .ch_load_stb(ch_load_stb), .err_pulse(err_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Vector: {op[1:0], addr[1:0], data[7:0], exp[7:0], req[3:0]}
  // op 0 = write, 1 = read and compare, 2 = set live counter to {data,exp}
  localparam int NV = 20;
  localparam logic [23:0] VEC [NV] = '{
    {2'd1, 2'd1, 8'h00, 8'h78, 4'd7},  // R7 first read is low byte
    {2'd1, 2'd1, 8'h00, 8'h56, 4'd7},  // R7 then high byte
    {2'd1, 2'd3, 8'h00, 8'h00, 4'd1},  // R1 command port reads zero
    {2'd1, 2'd1, 8'h00, 8'h78, 4'd1},  // R1 order untouched by it
    {2'd1, 2'd1, 8'h00, 8'h56, 4'd7},
    {2'd0, 2'd3, 8'h40, 8'h00, 4'd8},  // R8 latch channel 1
    {2'd2, 2'd1, 8'hBE, 8'hEF, 4'd8},
    {2'd1, 2'd1, 8'h00, 8'h78, 4'd8},  // R8 frozen low byte
    {2'd0, 2'd3, 8'h40, 8'h00, 4'd9},  // R9 second latch ignored
    {2'd1, 2'd1, 8'h00, 8'h56, 4'd8},  // R8 frozen high byte, release
    {2'd1, 2'd1, 8'h00, 8'hEF, 4'd8},  // R8 live again
    {2'd1, 2'd1, 8'h00, 8'hBE, 4'd8},
    {2'd0, 2'd3, 8'h40, 8'h00, 4'd8},  // R8 latch 0xBEEF
    {2'd2, 2'd1, 8'h01, 8'h02, 4'd8},
    {2'd1, 2'd1, 8'h00, 8'hEF, 4'd8},
    {2'd2, 2'd1, 8'h03, 8'h04, 4'd9},
    {2'd0, 2'd3, 8'h40, 8'h00, 4'd9},  // R9 ignored mid-read
    {2'd1, 2'd1, 8'h00, 8'hBE, 4'd9},
    {2'd1, 2'd1, 8'h00, 8'h04, 4'd9},  // R9 released, live 0x0304
    {2'd1, 2'd1, 8'h00, 8'h03, 4'd9}
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    cnt_live = {16'h9ABC, 16'h5678, 16'h1234};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check("R11 reload", ch_reload, '0);
    check("R11 mode", ch_mode, '0);
    check("R11 strobe", ch_load_stb, '0);
    check("R11 err", err_pulse, 1'b0);
    check("R11 rdata", bus_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op, a;
      logic [7:0] d, e;
      logic [3:0] rq;
      {op, a, d, e, rq} = VEC[i];
      case (op)
        2'd0: wr(a, d);
        2'd1: begin rd(a, rb); check($sformatf("R%0d vec %0d", rq, i), rb, e); end
        default: cnt_live[a*CNT_W +: CNT_W] = {d, e};
      endcase
    end

    // R10 write before any command
    wr(2'd2, 8'h55);
    check("R10 err", err_pulse, 1'b1);
    check("R10 strobe", ch_load_stb, '0);
    check("R10 reload", ch_reload[32 +: 16], 16'h0000);

    // R3 readback command
    wr(2'd3, 8'hC0);
    check("R3 err", err_pulse, 1'b1);
    check("R3 mode", ch_mode, '0);

    // R2 / R6 channel 0, low-then-high, mode 2, binary
    wr(2'd3, 8'h34);
    check("R2 err", err_pulse, 1'b0);
    check("R2 mode", ch_mode[2:0], 3'd2);
    check("R2 bcd", ch_bcd[0], 1'b0);
    wr(2'd0, 8'h9C);
    check("R6 no strobe on low", ch_load_stb, 3'b000);
    check("R6 low", ch_reload[15:0], 16'h009C);
    wr(2'd0, 8'h2E);
    check("R12 strobe on high", ch_load_stb, 3'b001);
    check("R6 full", ch_reload[15:0], 16'h2E9C);
    wr(2'd0, 8'h11);
    check("R6 wraps to low", ch_reload[15:0], 16'h2E11);
    check("R6 no strobe", ch_load_stb, 3'b000);

    // R4 channel 2, low only, mode 3, BCD
    wr(2'd3, 8'h97);
    check("R2 ch2 mode", ch_mode[8:6], 3'd3);
    check("R2 ch2 bcd", ch_bcd[2], 1'b1);
    wr(2'd2, 8'hAB);
    check("R4 strobe", ch_load_stb, 3'b100);
    check("R4 low", ch_reload[32 +: 16], 16'h00AB);
    wr(2'd2, 8'hCD);
    check("R4 again", ch_reload[32 +: 16], 16'h00CD);
    @(negedge clk);
    check("R12 one cycle", ch_load_stb, 3'b000);

    // R5 channel 2, high only, mode 0
    wr(2'd3, 8'hA0);
    check("R2 ch2 mode0", ch_mode[8:6], 3'd0);
    wr(2'd2, 8'h7F);
    check("R5 strobe", ch_load_stb, 3'b100);
    check("R5 high", ch_reload[32 +: 16], 16'h7FCD);
    wr(2'd2, 8'h01);
    check("R5 again", ch_reload[32 +: 16], 16'h01CD);

    // R2 latch command leaves mode untouched
    wr(2'd3, 8'h00);
    check("R2 latch keeps mode", ch_mode[2:0], 3'd2);
    check("R8 latch no reload change", ch_reload[15:0], 16'h2E11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule